// File: doc/BRIEF.md
# Two-Segment RAM Store Protection Gate

This block sits on the write path into a RAM array and decides, for every store, whether the store may go ahead. It holds two protection segments. Each segment is a range of word addresses with an inclusive lower bound and an exclusive upper bound. Each segment also has two enable bits: one for user-data stores and one for supervisor-data stores. Software programs the segments through a small 32-bit register interface, and a register write with reserved bits set raises a format-error pulse.

One input bit selects the meaning of the segments. In deny mode a store that lands in an enabled segment is refused. In allow mode a store is refused unless it lands in at least one enabled segment. Protection only applies once some enable bit is set. Double-word stores are checked on both of their words. A refused store has its RAM write enable dropped in the same cycle. One cycle later a single-cycle fault pulse appears, carrying the byte address and the space code of that store.

Top module: `wprot_gate`

## Requirements
- R1: After reset every bound and enable field reads back as zero, and no store is refused in either mode.
- R2: Selecting a lower-bound register (cfg_sel 0 for segment 0, 2 for segment 1) reads the word bound in bits [22:0], the user enable in bit 23 and the supervisor enable in bit 24, with all other bits zero; a write stores the same fields.
- R3: Selecting an upper-bound register (cfg_sel 1 for segment 0, 3 for segment 1) reads and writes the word bound in bits [22:0], with all other bits reading zero.
- R4: The cycle after a register write, cfg_err is high for one cycle exactly when a lower-bound write had any of bits [31:25] set or an upper-bound write had any of bits [31:23] set. The legal fields are stored regardless.
- R5: The word address checked is st_addr[22:2]; store-address bits [31:23] and [1:0] have no effect on the decision.
- R6: A segment applies to a store with space code 4'hA only if its user enable is set, and to space code 4'hB only if its supervisor enable is set; any other space code matches no segment.
- R7: A segment matches when its lower bound <= word address and word address < its upper bound. For a double-word store (st_size 2'd3), the word address with bit 0 forced to 1 must also be below the upper bound.
- R8: While all four enable bits are zero, every store is allowed.
- R9: With block_mode = 1, a store that matches either segment is refused.
- R10: With block_mode = 0 and some enable set, a store is refused unless it matches at least one segment.
- R11: ram_we equals st_valid in the same cycle unless the store is refused. The cycle after a refused store, fault is high for one cycle with fault_addr and fault_space equal to that store's st_addr and st_space. fault stays low after allowed stores and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: bit 0 picks the upper bound, bit 1 picks the segment |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the selected register (combinational) |
| cfg_err | output | 1 | Format-error pulse, one cycle after a bad write |
| block_mode | input | 1 | 1: segments are refused regions; 0: segments are the only allowed regions |
| st_valid | input | 1 | A store is presented this cycle |
| st_addr | input | 32 | Store byte address |
| st_space | input | 4 | Access-space code (4'hA user data, 4'hB supervisor data) |
| st_size | input | 2 | Store size: 0 byte, 1 half, 2 word, 3 double word |
| ram_we | output | 1 | Write enable to the RAM, dropped for a refused store |
| fault | output | 1 | One-cycle refusal pulse |
| fault_addr | output | 32 | Byte address of the refused store |
| fault_space | output | 4 | Space code of the refused store |

## Verification
The bench checks the range edges. It stores at the lower bound, the last word inside, the upper bound and the word below the lower bound. A design that made the upper bound inclusive, or the lower bound exclusive, would refuse or pass one word wrongly. It stores a double word whose second word crosses the upper bound. A design that skipped the second word would then get a different answer in each mode. It drives stores from the wrong space, stores with high address bits set, and stores made with every enable cleared. Swapped enable bits, a missing address mask or window-mode checking with nothing enabled would each refuse stores that should pass. It also writes reserved bits into both register kinds. A design that masked the wrong ranges would raise cfg_err on a legal enable write, or corrupt the stored fields.

// File: rtl/wprot_pkg.sv
`timescale 1ns/1ps
package wprot_pkg;
    // width of a stored word bound
    localparam int WORD_W = 23;
    localparam logic [3:0] SPC_USER = 4'hA;
    localparam logic [3:0] SPC_SUPV = 4'hB;
    localparam logic [1:0] SZ_DOUBLE = 2'd3;

    typedef struct packed {
        logic [1:0]        en;   // [0] user, [1] supervisor
        logic [WORD_W-1:0] lo;   // inclusive lower word bound
        logic [WORD_W-1:0] hi;   // exclusive upper word bound
    } seg_cfg_t;
endpackage

// File: rtl/wprot_regs.sv
`timescale 1ns/1ps
module wprot_regs
    import wprot_pkg::*;
#(
    parameter int NSEG   = 2,
    parameter int DATA_W = 32,
    parameter int SEL_W  = $clog2(2*NSEG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [SEL_W-1:0]           cfg_sel,
    input  logic [DATA_W-1:0]          cfg_wdata,
    output logic [DATA_W-1:0]          cfg_rdata,
    output logic                       cfg_err,
    output seg_cfg_t [NSEG-1:0]        segs,
    output logic                       any_en
);
    localparam int EN_LSB = WORD_W;
    localparam int LO_RSV = WORD_W + 2;

    typedef struct packed {
        seg_cfg_t [NSEG-1:0] seg;
        logic                err;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d     = regs_q;
        regs_d.err = 1'b0;
        if (cfg_we) begin
            for (int s = 0; s < NSEG; s++) begin
                if (int'(cfg_sel[SEL_W-1:1]) == s) begin
                    if (cfg_sel[0]) begin
                        regs_d.seg[s].hi = cfg_wdata[WORD_W-1:0];
                        regs_d.err       = |cfg_wdata[DATA_W-1:WORD_W];
                    end else begin
                        regs_d.seg[s].lo = cfg_wdata[WORD_W-1:0];
                        regs_d.seg[s].en = cfg_wdata[EN_LSB+1:EN_LSB];
                        regs_d.err       = |cfg_wdata[DATA_W-1:LO_RSV];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        cfg_rdata = '0;
        any_en    = 1'b0;
        for (int s = 0; s < NSEG; s++) begin
            any_en = any_en | (|regs_q.seg[s].en);
            if (int'(cfg_sel[SEL_W-1:1]) == s) begin
                if (cfg_sel[0]) begin
                    cfg_rdata[WORD_W-1:0] = regs_q.seg[s].hi;
                end else begin
                    cfg_rdata[WORD_W-1:0]        = regs_q.seg[s].lo;
                    cfg_rdata[EN_LSB+1:EN_LSB]   = regs_q.seg[s].en;
                end
            end
        end
    end

    assign segs    = regs_q.seg;
    assign cfg_err = regs_q.err;

    assert_lo_fmt_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel[0] && (|cfg_wdata[DATA_W-1:LO_RSV])) |=> cfg_err);
    assert_hi_fmt_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel[0] && (|cfg_wdata[DATA_W-1:WORD_W])) |=> cfg_err);
    assert_err_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> !cfg_err);
endmodule

// File: rtl/wprot_seg_hit.sv
`timescale 1ns/1ps
module wprot_seg_hit
    import wprot_pkg::*;
#(
    parameter int SPC_W = 4,
    parameter int WA_W  = WORD_W - 2
) (
    input  seg_cfg_t         cfg,
    input  logic [WA_W-1:0]  wa,
    input  logic [SPC_W-1:0] space,
    input  logic             dbl,
    output logic             hit
);
    logic [WORD_W-1:0] wa_first;
    logic [WORD_W-1:0] wa_last;
    logic              en_sel;

    always_comb begin
        wa_first = WORD_W'(wa);
        wa_last  = wa_first | WORD_W'(dbl);
        en_sel   = ((space == SPC_W'(SPC_USER)) && cfg.en[0]) ||
                   ((space == SPC_W'(SPC_SUPV)) && cfg.en[1]);
        hit      = en_sel && (wa_first >= cfg.lo) && (wa_last < cfg.hi);
    end

    always_comb begin
        if (hit) begin
            assert_hit_enabled_R6: assert (cfg.en != 2'b00);
            assert_hit_below_hi_R7: assert (wa_first < cfg.hi);
        end
    end
endmodule

// File: rtl/wprot_gate.sv
`timescale 1ns/1ps
module wprot_gate
    import wprot_pkg::*;
#(
    parameter int NSEG   = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SPC_W  = 4,
    parameter int SEL_W  = $clog2(2*NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              cfg_err,
    input  logic              block_mode,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SPC_W-1:0]  st_space,
    input  logic [1:0]        st_size,
    output logic              ram_we,
    output logic              fault,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [SPC_W-1:0]  fault_space
);
    localparam int WA_W = WORD_W - 2;

    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] addr;
        logic [SPC_W-1:0]  space;
    } rep_t;

    seg_cfg_t [NSEG-1:0] segs;
    logic                any_en;
    logic [NSEG-1:0]     hits;
    logic [WA_W-1:0]     wa;
    logic                dbl;
    logic                refuse;
    rep_t                rep_d, rep_q;

    wprot_regs #(
        .NSEG   (NSEG),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_err   (cfg_err),
        .segs      (segs),
        .any_en    (any_en)
    );

    assign wa  = st_addr[WORD_W-1:2];
    assign dbl = (st_size == SZ_DOUBLE);

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        wprot_seg_hit #(
            .SPC_W (SPC_W),
            .WA_W  (WA_W)
        ) u_hit (
            .cfg   (segs[g]),
            .wa    (wa),
            .space (st_space),
            .dbl   (dbl),
            .hit   (hits[g])
        );
    end

    always_comb begin
        refuse = any_en && (block_mode ? (|hits) : !(|hits));
        ram_we = st_valid && !refuse;
        rep_d  = rep_q;
        rep_d.flag = st_valid && refuse;
        if (st_valid && refuse) begin
            rep_d.addr  = st_addr;
            rep_d.space = st_space;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign fault       = rep_q.flag;
    assign fault_addr  = rep_q.addr;
    assign fault_space = rep_q.space;

    assert_inactive_allows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !any_en) |-> ram_we);
    assert_allowed_no_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !fault);
    assert_idle_no_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> !fault);
    assert_refused_reported_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !ram_we) |=> (fault && fault_addr == $past(st_addr)
                                   && fault_space == $past(st_space)));
endmodule

// File: tb/test_wprot_gate.sv
`timescale 1ns/1ps
module test_wprot_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic        block_mode = 1'b0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic [3:0]  st_space = '0;
    logic [1:0]  st_size = '0;
    logic        ram_we;
    logic        fault;
    logic [31:0] fault_addr;
    logic [3:0]  fault_space;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench mirror of the programmed fields
    logic [22:0] m_lo [2];
    logic [22:0] m_hi [2];
    logic [1:0]  m_en [2];

    typedef struct packed {
        logic        f;
        logic [31:0] a;
        logic [3:0]  sp;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    wprot_gate i_wprot_gate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .block_mode(block_mode), .st_valid(st_valid), .st_addr(st_addr),
        .st_space(st_space), .st_size(st_size), .ram_we(ram_we),
        .fault(fault), .fault_addr(fault_addr), .fault_space(fault_space)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic model_refuse(logic [31:0] a, logic [3:0] sp,
                                          logic [1:0] sz, logic blk);
        logic [22:0] w, wl;
        logic active, any;
        w  = {2'b00, a[22:2]};
        wl = (sz == 2'd3) ? (w | 23'd1) : w;
        active = 1'b0;
        any    = 1'b0;
        for (int s = 0; s < 2; s++) begin
            logic ok;
            active = active | (m_en[s] != 2'b00);
            ok = ((sp == 4'hA) && m_en[s][0]) || ((sp == 4'hB) && m_en[s][1]);
            if (ok && (w >= m_lo[s]) && (wl < m_hi[s])) any = 1'b1;
        end
        return active && (blk ? any : !any);
    endfunction

    task automatic cfg_write(logic [1:0] sel, logic [31:0] d, string tag);
        logic e;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        if (sel[0]) begin
            m_hi[sel[1]] = d[22:0];
            e = |d[31:23];
        end else begin
            m_lo[sel[1]] = d[22:0];
            m_en[sel[1]] = d[24:23];
            e = |d[31:25];
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check(tag, {31'd0, cfg_err}, {31'd0, e});
    endtask

    task automatic cfg_read(logic [1:0] sel, string tag);
        logic [31:0] e;
        @(negedge clk);
        cfg_sel = sel;
        #1;
        if (sel[0]) e = {9'd0, m_hi[sel[1]]};
        else        e = {7'd0, m_en[sel[1]], m_lo[sel[1]]};
        check(tag, cfg_rdata, e);
    endtask

    task automatic store(logic [31:0] a, logic [3:0] sp, logic [1:0] sz, string tag);
        exp_t it;
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_space = sp; st_size = sz;
        #1;
        it.f  = model_refuse(a, sp, sz, block_mode);
        it.a  = a;
        it.sp = sp;
        check({tag, " / R11 ram_we"}, {31'd0, ram_we}, {31'd0, !it.f});
        expq.push_back(it);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    // monitor: compares the registered fault report against the queue
    initial begin
        exp_t e;
        wait (rst_n);
        forever begin
            @(posedge clk);
            #5;
            if (expq.size() > 0) begin
                e = expq.pop_front();
                check("R11 fault pulse", {31'd0, fault}, {31'd0, e.f});
                if (e.f) begin
                    check("R11 fault_addr", fault_addr, e.a);
                    check("R11 fault_space", {28'd0, fault_space}, {28'd0, e.sp});
                end
            end else begin
                check("R11 no pulse when idle", {31'd0, fault}, 32'd0);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (all requirements): actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_lo[s] = '0; m_hi[s] = '0; m_en[s] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 fault after reset", {31'd0, fault}, 32'd0);
        check("R1 cfg_err after reset", {31'd0, cfg_err}, 32'd0);
        for (int r = 0; r < 4; r++) cfg_read(2'(r), "R1 readback zero");
        block_mode = 1'b0;
        store(32'h0000_0400, 4'hA, 2'd2, "R1 window mode store after reset");
        block_mode = 1'b1;
        store(32'h0000_0000, 4'hB, 2'd3, "R1 block mode store after reset");

        // R2/R3: program segments and read back
        cfg_write(2'd0, 32'h0080_0100, "R2 seg0 lower write user enable");
        cfg_write(2'd1, 32'h0000_0200, "R3 seg0 upper write");
        cfg_write(2'd2, 32'h0100_0300, "R2 seg1 lower write supervisor enable");
        cfg_write(2'd3, 32'h0000_0305, "R3 seg1 upper write");
        for (int r = 0; r < 4; r++) cfg_read(2'(r), "R2 R3 readback");

        // block mode: R9, R7, R6, R5
        block_mode = 1'b1;
        store(32'h0000_0100 << 2, 4'hA, 2'd2, "R7 R9 lower bound inclusive");
        store(32'h0000_01FF << 2, 4'hA, 2'd0, "R7 R9 last word inside");
        store(32'h0000_0200 << 2, 4'hA, 2'd2, "R7 upper bound exclusive");
        store(32'h0000_00FF << 2, 4'hA, 2'd1, "R7 below lower bound");
        store(32'h0000_0150 << 2, 4'hB, 2'd2, "R6 supervisor ignores user enable");
        store(32'h0000_0150 << 2, 4'h8, 2'd2, "R6 other space matches nothing");
        store(32'h7F80_0000 | (32'h0150 << 2) | 32'h3, 4'hA, 2'd0, "R5 upper address bits masked");
        store(32'h0000_0304 << 2, 4'hB, 2'd2, "R9 seg1 word hit");
        store(32'h0000_0304 << 2, 4'hB, 2'd3, "R7 double crossing upper bound");
        store(32'h0000_0302 << 2, 4'hB, 2'd3, "R7 R9 double inside");

        // window mode: R10
        block_mode = 1'b0;
        store(32'h0000_0302 << 2, 4'hB, 2'd2, "R10 inside supervisor window");
        store(32'h0000_0400 << 2, 4'hB, 2'd2, "R10 outside every window");
        store(32'h0000_0150 << 2, 4'hA, 2'd2, "R10 inside user window");
        store(32'h0000_0304 << 2, 4'hA, 2'd2, "R6 R10 wrong space for seg1");
        store(32'h0000_0304 << 2, 4'hB, 2'd3, "R7 R10 double crossing upper bound");
        store(32'h0000_0304 << 2, 4'hB, 2'd2, "R10 single word last inside");

        // R4: format errors, legal fields still stored
        cfg_write(2'd0, 32'h8080_0100, "R4 lower write reserved bit 31");
        cfg_write(2'd3, 32'h0080_0305, "R4 upper write reserved bit 23");
        cfg_write(2'd2, 32'h0180_0300, "R4 lower write both enables legal");
        cfg_write(2'd1, 32'h4000_0200, "R4 upper write reserved bit 30");
        for (int r = 0; r < 4; r++) cfg_read(2'(r), "R4 fields stored after bad write");
        store(32'h0000_0302 << 2, 4'hA, 2'd2, "R6 R10 seg1 user enable now set");

        // R8: all enables cleared
        cfg_write(2'd0, 32'h0000_0100, "R8 clear seg0 enables");
        cfg_write(2'd2, 32'h0000_0300, "R8 clear seg1 enables");
        store(32'h0000_0400 << 2, 4'hB, 2'd2, "R8 window mode nothing enabled");
        block_mode = 1'b1;
        store(32'h0000_0100 << 2, 4'hA, 2'd3, "R8 block mode nothing enabled");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule